// File: doc/BRIEF.md
# Best-Offset Prefetch Learning Engine

This block chooses the line offset an L2 prefetcher adds to each demand line address. It keeps a fixed list of 46 signed candidate offsets and tries one of them on each qualifying access, in list order. The try is a lookup of the line address minus the candidate in an external table of recently requested lines. A hit earns that candidate a point. Once any score has reached its ceiling at the end of a pass over the list, or once a fixed number of passes has gone by, the learning phase closes. The highest-scoring candidate then becomes the live prefetch offset. If even the best score is too weak, prefetching is switched off instead.

An access qualifies when it misses in L2, or when it hits a line whose prefetch flag is set. In the second case the block asks the cache to clear that flag. On each qualifying access the block also produces a prefetch request at line plus live offset, provided that line stays inside the same 64-line page. It also pushes the demand line to an external delay queue. The recent-request table, the delay queue and the miss-queue throttle sit outside the block.

Top module: `bo_learner`

## Requirements
- R1: Candidates are stepped through by index 0..45. Index 2k holds +m(k) and index 2k+1 holds −m(k), where m(k) is k+1 for k below 16 and then 18, 20, 24, 30, 32, 36, 40. For a qualifying access, `rr_query_line` equals `acc_line` minus the current candidate in the same cycle.
- R2: An access qualifies when `acc_valid` is high and either `acc_hit` is low, or `acc_hit` and `acc_pf_bit` are both high. `pf_bit_clear` is high in the same cycle exactly when `acc_valid`, `acc_hit` and `acc_pf_bit` are all high. A non-qualifying access changes no learning state and produces no request.
- R3: When `rr_hit` is high on a qualifying access, that candidate's 5-bit score rises by one and holds at 31. If the new score is greater than or equal to the running maximum, it becomes the maximum and the candidate becomes the best offset. On ties, the later candidate wins.
- R4: Each qualifying access advances the candidate index by one. After index 45 it returns to 0, and the pass counter increments.
- R5: A phase ends on the qualifying access at index 45 if, after that access, the maximum is 31 or 100 passes are complete. On the next cycle `phase_done` pulses for one cycle, `best_score` shows that maximum, and scores, maximum, best offset, pass count and index all restart from zero.
- R6: At phase end, `pf_offset` (7-bit two's complement) takes the best offset. It takes 1 if the best offset is zero.
- R7: At phase end, `pf_offset` becomes 0 if the maximum is at most the weak-score limit. That limit is 1 when `small_llc` is low and 10 when it is high.
- R8: One cycle after a qualifying access, `pf_valid` pulses with `pf_line` = line + offset. This happens only if the offset is nonzero and bits [31:6] of the target equal those of the line. The offset used is the one in force after that access, including a change made by that same access.
- R9: One cycle after a qualifying access, `dq_valid` pulses with `dq_line` equal to the access line. This happens if the offset is zero or a prefetch is issued. When the target leaves the page, no push happens.
- R10: After reset `pf_offset` is 1, `best_score` is 0, and `pf_valid`, `dq_valid` and `phase_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| small_llc | input | 1 | Selects the higher weak-score limit |
| acc_valid | input | 1 | An L2 demand access this cycle |
| acc_line | input | 32 | Line address of the access |
| acc_hit | input | 1 | Access hit in L2 |
| acc_pf_bit | input | 1 | Prefetch flag of the hit line |
| rr_query_valid | output | 1 | Recent-request lookup is meaningful |
| rr_query_line | output | 32 | Line looked up in the recent-request table |
| rr_hit | input | 1 | Lookup result, same cycle |
| pf_bit_clear | output | 1 | Clear the prefetch flag of the hit line |
| pf_valid | output | 1 | Prefetch request pulse |
| pf_line | output | 32 | Prefetch target line |
| dq_valid | output | 1 | Delay-queue push pulse |
| dq_line | output | 32 | Line pushed to the delay queue |
| pf_offset | output | 7 | Live prefetch offset, signed |
| best_score | output | 5 | Maximum score of the last phase |
| phase_done | output | 1 | One-cycle pulse after a phase closes |

## Verification
The access that closes a phase also issues a prefetch. That prefetch must already use the offset chosen by this access, not the old one, and in the same cycle the final score bump competes with the phase clear. The bench reaches this case at the end of every phase: a saturating stream ends in +40, a silent phase turns prefetching off, and a weak phase is run in both limit modes. A behavioural model computes the request line and page gate from the updated offset and compares them on every clock.

// File: rtl/bo_pkg.sv
package bo_pkg;
  localparam int NCAND = 46;
  localparam int OFF_W = 7;
  localparam int IDX_W = $clog2(NCAND);

  typedef logic signed [OFF_W-1:0] off_t;

  // index 2k -> +mag(k), index 2k+1 -> -mag(k)
  function automatic off_t cand_offset(input logic [IDX_W-1:0] idx);
    int k;
    int mag;
    k = int'(idx) >> 1;
    if (k < 16) mag = k + 1;
    else begin
      case (k)
        16:      mag = 18;
        17:      mag = 20;
        18:      mag = 24;
        19:      mag = 30;
        20:      mag = 32;
        21:      mag = 36;
        default: mag = 40;
      endcase
    end
    return idx[0] ? off_t'(-mag) : off_t'(mag);
  endfunction
endpackage

// File: rtl/bo_score_table.sv
module bo_score_table
  import bo_pkg::*;
#(
  parameter int SCORE_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic               hit,
  input  logic [IDX_W-1:0]   idx,
  input  off_t               cand,
  input  logic               clr,
  output logic [SCORE_W-1:0] max_nxt,
  output off_t               best_nxt,
  output logic [SCORE_W-1:0] max_q,
  output off_t               best_q
);
  localparam logic [SCORE_W-1:0] SMAX = {SCORE_W{1'b1}};

  logic [SCORE_W-1:0] score_q [NCAND];
  logic [SCORE_W-1:0] cur, bumped;
  logic               bump;

  assign cur    = score_q[idx];
  assign bumped = (cur == SMAX) ? cur : cur + 1'b1;
  assign bump   = step & hit;

  always_comb begin
    max_nxt  = max_q;
    best_nxt = best_q;
    if (bump && bumped >= max_q) begin
      max_nxt  = bumped;
      best_nxt = cand;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < NCAND; i++) score_q[i] <= '0;
      max_q  <= '0;
      best_q <= '0;
    end else if (bump) begin
      score_q[idx] <= bumped;
      max_q        <= max_nxt;
      best_q       <= best_nxt;
    end
  end

  // R3: running maximum never falls within a phase
  a_r3_max_monotone: assert property (@(posedge clk) disable iff (rst)
    !clr |=> max_q >= $past(max_q));
endmodule

// File: rtl/bo_phase_ctrl.sv
module bo_phase_ctrl
  import bo_pkg::*;
#(
  parameter int SCORE_W     = 5,
  parameter int ROUND_LIMIT = 100,
  parameter int BAD_NORMAL  = 1,
  parameter int BAD_SMALL   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic               small_llc,
  input  logic [SCORE_W-1:0] max_nxt,
  input  off_t               best_nxt,
  output logic [IDX_W-1:0]   ptr,
  output logic               phase_end,
  output off_t               off_now,
  output off_t               off_q,
  output logic [SCORE_W-1:0] best_score_q,
  output logic               done_q
);
  localparam int RW = $clog2(ROUND_LIMIT + 1);
  localparam logic [SCORE_W-1:0] SMAX  = {SCORE_W{1'b1}};
  localparam logic [SCORE_W-1:0] BAD_N = SCORE_W'(BAD_NORMAL);
  localparam logic [SCORE_W-1:0] BAD_S = SCORE_W'(BAD_SMALL);
  localparam logic [IDX_W-1:0]   LAST  = IDX_W'(NCAND - 1);
  localparam logic [RW-1:0]      RLAST = RW'(ROUND_LIMIT - 1);

  logic [RW-1:0]      round_q;
  logic               round_end;
  logic [SCORE_W-1:0] bad_lim;
  off_t               chosen, new_off;

  assign round_end = step && (ptr == LAST);
  assign phase_end = round_end && (max_nxt == SMAX || round_q == RLAST);
  assign bad_lim   = small_llc ? BAD_S : BAD_N;
  assign chosen    = (best_nxt == '0) ? off_t'(1) : best_nxt;
  assign new_off   = (max_nxt <= bad_lim) ? off_t'(0) : chosen;
  assign off_now   = phase_end ? new_off : off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr          <= '0;
      round_q      <= '0;
      off_q        <= off_t'(1);
      best_score_q <= '0;
      done_q       <= 1'b0;
    end else begin
      done_q <= phase_end;
      if (phase_end) begin
        off_q        <= new_off;
        best_score_q <= max_nxt;
        ptr          <= '0;
        round_q      <= '0;
      end else if (round_end) begin
        ptr     <= '0;
        round_q <= round_q + 1'b1;
      end else if (step) begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  // R4: index stays inside the candidate list
  a_r4_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
    ptr < IDX_W'(NCAND));
  // R5: pass counter never reaches the limit without closing the phase
  a_r5_round_bound: assert property (@(posedge clk) disable iff (rst)
    round_q < RW'(ROUND_LIMIT));
endmodule

// File: rtl/bo_issue_gate.sv
module bo_issue_gate
  import bo_pkg::*;
#(
  parameter int LINE_W   = 32,
  parameter int PAGE_LOG = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [LINE_W-1:0] line,
  input  off_t              off_now,
  output logic              pf_valid,
  output logic [LINE_W-1:0] pf_line,
  output logic              dq_valid,
  output logic [LINE_W-1:0] dq_line
);
  logic [LINE_W-1:0] off_ext, tgt;
  logic              same_page, off_zero, go_pf, go_dq;

  assign off_ext   = {{(LINE_W-OFF_W){off_now[OFF_W-1]}}, off_now};
  assign tgt       = line + off_ext;
  assign same_page = tgt[LINE_W-1:PAGE_LOG] == line[LINE_W-1:PAGE_LOG];
  assign off_zero  = (off_now == '0);
  assign go_pf     = step && !off_zero && same_page;
  assign go_dq     = step && (off_zero || same_page);

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_valid <= 1'b0;
      dq_valid <= 1'b0;
      pf_line  <= '0;
      dq_line  <= '0;
    end else begin
      pf_valid <= go_pf;
      dq_valid <= go_dq;
      if (go_pf) pf_line <= tgt;
      if (go_dq) dq_line <= line;
    end
  end

  // R8: a request never leaves the page of the line pushed with it
  a_r8_pf_same_page: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> dq_valid && pf_line[LINE_W-1:PAGE_LOG] == dq_line[LINE_W-1:PAGE_LOG]);
endmodule

// File: rtl/bo_learner.sv
module bo_learner
  import bo_pkg::*;
#(
  parameter int LINE_W      = 32,
  parameter int PAGE_LOG    = 6,
  parameter int SCORE_W     = 5,
  parameter int ROUND_LIMIT = 100,
  parameter int BAD_NORMAL  = 1,
  parameter int BAD_SMALL   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               small_llc,
  input  logic               acc_valid,
  input  logic [LINE_W-1:0]  acc_line,
  input  logic               acc_hit,
  input  logic               acc_pf_bit,
  output logic               rr_query_valid,
  output logic [LINE_W-1:0]  rr_query_line,
  input  logic               rr_hit,
  output logic               pf_bit_clear,
  output logic               pf_valid,
  output logic [LINE_W-1:0]  pf_line,
  output logic               dq_valid,
  output logic [LINE_W-1:0]  dq_line,
  output logic [OFF_W-1:0]   pf_offset,
  output logic [SCORE_W-1:0] best_score,
  output logic               phase_done
);
  logic               step, phase_end;
  logic [IDX_W-1:0]   ptr;
  off_t               cand, off_now, off_q, best_nxt, best_q;
  logic [SCORE_W-1:0] max_nxt, max_q;

  assign step           = acc_valid && (!acc_hit || acc_pf_bit);
  assign pf_bit_clear   = acc_valid && acc_hit && acc_pf_bit;
  assign cand           = cand_offset(ptr);
  assign rr_query_valid = step;
  assign rr_query_line  = acc_line - {{(LINE_W-OFF_W){cand[OFF_W-1]}}, cand};
  assign pf_offset      = off_q;

  bo_score_table #(.SCORE_W(SCORE_W)) u_scores (
    .clk, .rst, .step, .hit(rr_hit), .idx(ptr), .cand, .clr(phase_end),
    .max_nxt, .best_nxt, .max_q, .best_q
  );

  bo_phase_ctrl #(
    .SCORE_W(SCORE_W), .ROUND_LIMIT(ROUND_LIMIT),
    .BAD_NORMAL(BAD_NORMAL), .BAD_SMALL(BAD_SMALL)
  ) u_ctrl (
    .clk, .rst, .step, .small_llc, .max_nxt, .best_nxt, .ptr, .phase_end,
    .off_now, .off_q, .best_score_q(best_score), .done_q(phase_done)
  );

  bo_issue_gate #(.LINE_W(LINE_W), .PAGE_LOG(PAGE_LOG)) u_issue (
    .clk, .rst, .step, .line(acc_line), .off_now,
    .pf_valid, .pf_line, .dq_valid, .dq_line
  );

  // R5: the cycle after a phase closes, the score table is empty
  a_r5_done_clears: assert property (@(posedge clk) disable iff (rst)
    phase_done |-> max_q == '0 && best_q == '0);
  // R7: a weak phase leaves prefetching off
  a_r7_weak_turns_off: assert property (@(posedge clk) disable iff (rst)
    phase_done && best_score <= ($past(small_llc) ? SCORE_W'(BAD_SMALL) : SCORE_W'(BAD_NORMAL))
    |-> pf_offset == '0);
  // R2: a plain hit produces no delay-queue push
  a_r2_plain_hit_quiet: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_hit && !acc_pf_bit |=> !dq_valid);
endmodule

// File: tb/bo_learner_test.sv
module bo_learner_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        small_llc = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_line = '0;
  logic        acc_hit = 1'b0;
  logic        acc_pf_bit = 1'b0;
  logic        rr_hit = 1'b0;
  logic        rr_query_valid, pf_bit_clear, pf_valid, dq_valid, phase_done;
  logic [31:0] rr_query_line, pf_line, dq_line;
  logic [6:0]  pf_offset;
  logic [4:0]  best_score;

  bo_learner uut (
    .clk, .rst, .small_llc, .acc_valid, .acc_line, .acc_hit, .acc_pf_bit,
    .rr_query_valid, .rr_query_line, .rr_hit, .pf_bit_clear, .pf_valid,
    .pf_line, .dq_valid, .dq_line, .pf_offset, .best_score, .phase_done
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  int mags[23] = '{1,2,3,4,5,6,7,8,9,10,11,12,13,14,15,16,18,20,24,30,32,36,40};
  int m_score[46];
  int m_max = 0, m_best = 0, m_ptr = 0, m_round = 0, m_off = 1, m_bs = 0;
  int hit_mode = 0;
  bit recent[logic [31:0]];
  bit saw_done;

  function automatic int cand(int i);
    return (i % 2 == 1) ? -mags[i/2] : mags[i/2];
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset_phase();
    for (int i = 0; i < 46; i++) m_score[i] = 0;
    m_max = 0; m_best = 0; m_ptr = 0; m_round = 0;
  endtask

  // one access; called at a falling edge, returns at the next falling edge
  task automatic step(bit v, logic [31:0] line, bit h, bit pb);
    bit elig, hit, done, e_pf, e_dq;
    logic [31:0] q, tgt, e_pfl;
    int s, c, lim;
    elig = v && (!h || pb);
    c = cand(m_ptr);
    q = line - 32'(c);
    hit = 1'b0;
    if (elig) begin
      case (hit_mode)
        0: hit = recent.exists(q);
        1: hit = 1'b0;
        default: hit = (m_ptr == 3 && m_round < 5);
      endcase
    end
    acc_valid = v; acc_line = line; acc_hit = h; acc_pf_bit = pb; rr_hit = hit;
    #1;
    chk(pf_bit_clear == (v && h && pb), "R2", "pf_bit_clear", pf_bit_clear, v && h && pb);
    chk(rr_query_valid == elig, "R2", "rr_query_valid", rr_query_valid, elig);
    if (elig) chk(rr_query_line == q, "R1 R4", "rr_query_line", rr_query_line, q);
    done = 0; e_pf = 0; e_dq = 0; e_pfl = '0;
    if (elig) begin
      if (hit) begin
        s = (m_score[m_ptr] < 31) ? m_score[m_ptr] + 1 : 31;
        m_score[m_ptr] = s;
        if (s >= m_max) begin m_max = s; m_best = c; end
      end
      if (m_ptr == 45) begin
        m_round++;
        if (m_max == 31 || m_round == 100) begin
          lim = small_llc ? 10 : 1;
          m_off = (m_best != 0) ? m_best : 1;
          if (m_max <= lim) m_off = 0;
          m_bs = m_max;
          done = 1;
          model_reset_phase();
        end else m_ptr = 0;
      end else m_ptr++;
      tgt = line + 32'(m_off);
      if (m_off == 0) e_dq = 1;
      else if (tgt[31:6] == line[31:6]) begin e_pf = 1; e_dq = 1; e_pfl = tgt; end
      if (hit_mode == 0) recent[line] = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    chk(pf_valid == e_pf, "R8", "pf_valid", pf_valid, e_pf);
    if (e_pf) chk(pf_line == e_pfl, "R8", "pf_line", pf_line, e_pfl);
    chk(dq_valid == e_dq, "R9", "dq_valid", dq_valid, e_dq);
    if (e_dq) chk(dq_line == line, "R9", "dq_line", dq_line, line);
    chk($signed(pf_offset) == m_off, "R6", "pf_offset", $signed(pf_offset), m_off);
    chk(best_score == 5'(m_bs), "R5", "best_score", best_score, m_bs);
    chk(phase_done == done, "R5", "phase_done", phase_done, done);
    if (done) saw_done = 1;
  endtask

  task automatic run_to_done(int limit, logic [31:0] base, bit seq);
    saw_done = 0;
    for (int i = 0; i < limit && !saw_done; i++) begin
      if (seq) step(1'b1, base + 32'(i), i[0], 1'b1);
      else     step(1'b1, $urandom, i[0], 1'b1);
      if (i % 7 == 3) step(1'b1, $urandom, 1'b1, 1'b0);
      if (i % 11 == 5) step(1'b0, $urandom, 1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_reset_phase();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(pf_offset == 7'd1, "R10", "reset pf_offset", pf_offset, 1);
    chk(best_score == 5'd0, "R10", "reset best_score", best_score, 0);
    chk(!pf_valid && !dq_valid && !phase_done, "R10", "reset pulses",
        {pf_valid, dq_valid, phase_done}, 0);

    // saturating stream: all positive candidates tie at 31, last one wins
    hit_mode = 0;
    run_to_done(3000, 32'h0001_0000, 1'b1);
    chk(saw_done, "R5", "saturation ends phase", saw_done, 1);
    chk($signed(pf_offset) == 40, "R3", "tie goes to +40", $signed(pf_offset), 40);
    chk(best_score == 5'd31, "R3", "saturated score", best_score, 31);

    // silent phase: page gate with +40, then prefetching turned off
    hit_mode = 1;
    step(1'b1, 32'h0002_0030, 1'b0, 1'b0);
    chk(!pf_valid && !dq_valid, "R8", "page cross blocks issue", pf_valid, 0);
    run_to_done(6000, 32'h0, 1'b0);
    chk(pf_offset == 7'd0, "R7", "no hits turns off", pf_offset, 0);
    step(1'b1, 32'h0003_0010, 1'b0, 1'b0);
    chk(dq_valid && !pf_valid, "R9", "offset zero pushes only", {dq_valid, pf_valid}, 2);

    // weak phase in small-cache mode
    hit_mode = 2; small_llc = 1'b1;
    run_to_done(6000, 32'h0, 1'b0);
    chk(pf_offset == 7'd0, "R7", "score 5 under limit 10", pf_offset, 0);
    chk(best_score == 5'd5, "R7", "weak score", best_score, 5);

    // same weak phase in normal mode keeps offset -2
    small_llc = 1'b0;
    run_to_done(6000, 32'h0, 1'b0);
    chk($signed(pf_offset) == -2, "R6", "offset -2 kept", $signed(pf_offset), -2);
    hit_mode = 1;
    step(1'b1, 32'h0000_4000, 1'b0, 1'b0);
    chk(!pf_valid && !dq_valid, "R8", "negative page cross", dq_valid, 0);
    step(1'b1, 32'h0000_4005, 1'b1, 1'b1);
    chk(pf_valid && pf_line == 32'h0000_4003, "R8", "negative offset target", pf_line, 32'h4003);
    step(1'b1, 32'h0000_4009, 1'b1, 1'b0);
    chk(!pf_valid && !dq_valid, "R2", "plain hit ignored", {pf_valid, dq_valid}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule